// File: doc/BRIEF.md
# Per-Core Deterministic Store Buffer

This block sits beside one core and captures every store the running thread makes during the parallel phase of a quantum. Captured stores stay private: nothing reaches shared memory until the runtime issues an explicit commit, and the commit then replays the held entries, one per cycle and oldest first, on a plain memory write port. Loads from the core look the buffer up in parallel with memory. A load that hits merges the buffered bytes over the memory word byte by byte.

Each address owns at most one entry. A later store to a held address folds its enabled bytes into that entry. A store to a new address when every entry is taken is refused, and a full trap is raised to the core. A save command streams the entries out over a one-entry-wide transfer port and empties the buffer. A restore command empties it and reloads it from the same port, so the buffered state can follow a thread across a context switch. A per-store direct flag lets the runtime bypass the buffer and write memory at once, for code that has opted out of deterministic execution.

Top module: `sb_store_buffer`

## Requirements
- R1: A store with `st_direct`=0 taken while idle (`st_valid` and `st_ready` high) is held in the buffer. It causes no memory write, and a store to an address not yet held raises `count` by one on the next cycle.
- R2: Commit (`cmd_op`=0) drives the held entries on the memory port, one per cycle in allocation order, starting the cycle after the command. `op_done` is high for one cycle after the last beat, with `count` at 0. A commit of an empty buffer gives `op_done` on the next cycle and no write.
- R3: A buffered store to an address not held while `count` equals the capacity raises `trap_full` in the same cycle and is dropped: `count` is unchanged and a later load of that address misses.
- R4: A buffered store to a held address replaces the bytes whose enable bit is set, ORs its enables into the entry, and leaves `count` unchanged. This holds even when the buffer is full, and no trap is raised.
- R5: For a load address, `ld_hit` is high if the address is held, and byte i of `ld_data` is the held byte when the entry's enable bit i is set, otherwise byte i of `mem_rdata`.
- R6: Save (`cmd_op`=1) streams the entries on `xfer_out_data`, one per cycle in allocation order from the cycle after the command. Each word is packed as {address, byte enables, data} from MSB to LSB, and `xfer_out_last` marks the final word. The buffer is then empty and `op_done` pulses.
- R7: Restore (`cmd_op`=2) empties the buffer and then takes one {address, byte enables, data} word per `xfer_in_valid` cycle, in order, until a word with `xfer_in_last`. Words beyond the capacity are dropped, and `op_done` pulses the cycle after the last word.
- R8: A store with `st_direct`=1 taken while idle appears on the memory port in the same cycle and leaves the buffer unchanged.
- R9: `st_ready` is low while a commit, save or restore is in progress and in a cycle where a command is presented. Operation code 3 is ignored.
- R10: After reset `count` is 0, `st_ready` is high, and `trap_full`, `mem_we`, `op_done` and `xfer_out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| st_valid | input | 1 | Store request |
| st_direct | input | 1 | Store bypasses the buffer |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| st_ready | output | 1 | Store can be taken this cycle |
| trap_full | output | 1 | Store refused, buffer full |
| ld_addr | input | ADDR_W | Load lookup address |
| mem_rdata | input | DATA_W | Memory word for the load address |
| ld_data | output | DATA_W | Load data after byte merge |
| ld_hit | output | 1 | Load address is held |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 commit, 1 save, 2 restore, 3 none |
| op_done | output | 1 | Command finished (one-cycle pulse) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_be | output | DATA_W/8 | Memory write byte enables |
| xfer_out_valid | output | 1 | Save word valid |
| xfer_out_data | output | ADDR_W+DATA_W/8+DATA_W | Save word |
| xfer_out_last | output | 1 | Final save word |
| xfer_in_valid | input | 1 | Restore word valid |
| xfer_in_data | input | ADDR_W+DATA_W/8+DATA_W | Restore word |
| xfer_in_last | input | 1 | Final restore word |
| count | output | $clog2(DEPTH+1) | Entries held |

## Verification
The bench builds the buffer with DEPTH=4, ADDR_W=4 and DATA_W=16, so the whole 16-word address space can be swept on every load check. The full condition is reached after four stores, and two byte lanes make partial-enable merging visible. With that size, several fill, merge, trap and commit rounds fit in a short run. A restore of five words pushes past the capacity, and a save-then-restore round trip can be compared address by address against an arithmetic model.

// File: rtl/sb_pkg.sv
// sb_pkg: command codes and controller states shared by the store buffer.
// Assumes: cmd_op is two bits wide at the top level.
package sb_pkg;
    typedef enum logic [1:0] {
        SB_OP_COMMIT  = 2'd0,
        SB_OP_SAVE    = 2'd1,
        SB_OP_RESTORE = 2'd2,
        SB_OP_NONE    = 2'd3
    } sb_op_e;

    typedef enum logic [1:0] {
        SB_IDLE   = 2'd0,
        SB_DRAIN  = 2'd1,
        SB_UNLOAD = 2'd2,
        SB_RELOAD = 2'd3
    } sb_state_e;
endpackage

// File: rtl/sb_entry_array.sv
// sb_entry_array: holds the buffered entries in allocation order and looks
// up store and load addresses against them.
// Assumes: st_en is raised only for stores that either hit or find room;
// rl_en and st_en are never high together; clr wins over everything.
module sb_entry_array #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          st_en,
    input  logic [ADDR_W-1:0]             st_addr,
    input  logic [DATA_W-1:0]             st_data,
    input  logic [DATA_W/8-1:0]           st_be,
    input  logic                          rl_en,
    input  logic [ADDR_W-1:0]             rl_addr,
    input  logic [DATA_W-1:0]             rl_data,
    input  logic [DATA_W/8-1:0]           rl_be,
    input  logic                          clr,
    input  logic [ADDR_W-1:0]             ld_addr,
    input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] rd_idx,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          full,
    output logic                          st_hit,
    output logic                          ld_hit,
    output logic [DATA_W-1:0]             ld_dat,
    output logic [DATA_W/8-1:0]           ld_be,
    output logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic [DATA_W/8-1:0]           rd_be
);
    localparam int BE_W  = DATA_W / 8;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] ent_addr [DEPTH];
    logic [DATA_W-1:0] ent_data [DEPTH];
    logic [BE_W-1:0]   ent_be   [DEPTH];
    logic [DEPTH-1:0]  st_match;
    logic [DEPTH-1:0]  ld_match;

    assign full   = (count == CNT_W'(DEPTH));
    assign st_hit = |st_match;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [ADDR_W-1:0] a_q;
        logic [DATA_W-1:0] d_q;
        logic [BE_W-1:0]   b_q;
        logic              live;
        logic              is_tail;

        assign live     = (CNT_W'(i) < count);
        assign is_tail  = (count == CNT_W'(i));
        assign st_match[i] = live && (a_q == st_addr);
        assign ld_match[i] = live && (a_q == ld_addr);
        assign ent_addr[i] = a_q;
        assign ent_data[i] = d_q;
        assign ent_be[i]   = b_q;

        // Merge into, allocate or reload this entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_q <= '0;
                d_q <= '0;
                b_q <= '0;
            end else if (st_en && st_match[i]) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (st_be[b]) d_q[8*b +: 8] <= st_data[8*b +: 8];
                end
                b_q <= b_q | st_be;
            end else if (st_en && !st_hit && is_tail) begin
                a_q <= st_addr;
                d_q <= st_data;
                b_q <= st_be;
            end else if (rl_en && is_tail) begin
                a_q <= rl_addr;
                d_q <= rl_data;
                b_q <= rl_be;
            end
        end
    end

    // Track how many entries are live.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (st_en && !st_hit && !full) begin
            count <= count + CNT_W'(1);
        end else if (rl_en && !full) begin
            count <= count + CNT_W'(1);
        end
    end

    // Select the entry a load address hits.
    always_comb begin
        ld_hit = 1'b0;
        ld_dat = '0;
        ld_be  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ld_match[i]) begin
                ld_hit = 1'b1;
                ld_dat = ent_data[i];
                ld_be  = ent_be[i];
            end
        end
    end

    // Read the entry addressed by the drain or save pointer.
    always_comb begin
        rd_addr = ent_addr[rd_idx];
        rd_data = ent_data[rd_idx];
        rd_be   = ent_be[rd_idx];
    end

    AST_ONE_ENTRY_PER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_match) <= 1); // R4

    AST_COUNT_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R7
endmodule

// File: rtl/sb_byte_merge.sv
// sb_byte_merge: overlays buffered bytes on the memory word for a load.
// Assumes: buf_be is meaningful only when hit is high.
module sb_byte_merge #(
    parameter int DATA_W = 32
) (
    input  logic                hit,
    input  logic [DATA_W-1:0]   buf_data,
    input  logic [DATA_W/8-1:0] buf_be,
    input  logic [DATA_W-1:0]   mem_data,
    output logic [DATA_W-1:0]   merged
);
    localparam int BE_W = DATA_W / 8;

    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        // Pick the buffered byte where the entry owns the lane.
        assign merged[8*b +: 8] = (hit && buf_be[b]) ? buf_data[8*b +: 8]
                                                     : mem_data[8*b +: 8];
    end
endmodule

// File: rtl/sb_ctrl.sv
// sb_ctrl: sequences commit, save and restore and walks the entry pointer.
// Assumes: commands are only honoured in the idle state; count comes from
// the entry array and drops to zero the cycle after clr.
module sb_ctrl
    import sb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cmd_valid,
    input  logic [1:0]                             cmd_op,
    input  logic [$clog2(DEPTH+1)-1:0]             count,
    input  logic                                   xfer_in_valid,
    input  logic                                   xfer_in_last,
    output logic                                   idle,
    output logic                                   drain,
    output logic                                   unload,
    output logic                                   reload,
    output logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] ptr,
    output logic                                   last_beat,
    output logic                                   clr,
    output logic                                   op_done
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    sb_state_e state;
    sb_op_e    op;

    assign op        = sb_op_e'(cmd_op);
    assign idle      = (state == SB_IDLE);
    assign drain     = (state == SB_DRAIN);
    assign unload    = (state == SB_UNLOAD);
    assign reload    = (state == SB_RELOAD);
    assign last_beat = ((CNT_W'(ptr) + CNT_W'(1)) == count);

    // Empty the array after the last streamed entry or at restore start.
    always_comb begin
        clr = ((drain || unload) && last_beat) ||
              (idle && cmd_valid && (op == SB_OP_RESTORE));
    end

    // Advance the command state machine and the entry pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SB_IDLE;
            ptr     <= '0;
            op_done <= 1'b0;
        end else begin
            op_done <= 1'b0;
            case (state)
                SB_IDLE: begin
                    if (cmd_valid) begin
                        case (op)
                            SB_OP_COMMIT, SB_OP_SAVE: begin
                                if (count == '0) begin
                                    op_done <= 1'b1;
                                end else begin
                                    state <= (op == SB_OP_COMMIT) ? SB_DRAIN : SB_UNLOAD;
                                    ptr   <= '0;
                                end
                            end
                            SB_OP_RESTORE: state <= SB_RELOAD;
                            default: ;
                        endcase
                    end
                end
                SB_DRAIN, SB_UNLOAD: begin
                    if (last_beat) begin
                        state   <= SB_IDLE;
                        op_done <= 1'b1;
                    end else begin
                        ptr <= ptr + IDX_W'(1);
                    end
                end
                SB_RELOAD: begin
                    if (xfer_in_valid && xfer_in_last) begin
                        state   <= SB_IDLE;
                        op_done <= 1'b1;
                    end
                end
                default: state <= SB_IDLE;
            endcase
        end
    end

    AST_DRAIN_ENDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && last_beat) |=> (op_done && count == '0)); // R2

    AST_BUSY_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (drain || unload) |=> (count <= $past(count))); // R9
endmodule

// File: rtl/sb_store_buffer.sv
// sb_store_buffer: private per-core buffer that holds stores until an
// explicit commit, forwards them to loads, traps when full, and can be
// saved and restored over a one-entry-wide transfer port.
// Assumes: a restore stream carries distinct addresses; mem_rdata is the
// memory word at ld_addr in the same cycle.
module sb_store_buffer
    import sb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                st_valid,
    input  logic                                st_direct,
    input  logic [ADDR_W-1:0]                   st_addr,
    input  logic [DATA_W-1:0]                   st_data,
    input  logic [DATA_W/8-1:0]                 st_be,
    output logic                                st_ready,
    output logic                                trap_full,
    input  logic [ADDR_W-1:0]                   ld_addr,
    input  logic [DATA_W-1:0]                   mem_rdata,
    output logic [DATA_W-1:0]                   ld_data,
    output logic                                ld_hit,
    input  logic                                cmd_valid,
    input  logic [1:0]                          cmd_op,
    output logic                                op_done,
    output logic                                mem_we,
    output logic [ADDR_W-1:0]                   mem_addr,
    output logic [DATA_W-1:0]                   mem_wdata,
    output logic [DATA_W/8-1:0]                 mem_be,
    output logic                                xfer_out_valid,
    output logic [ADDR_W+DATA_W/8+DATA_W-1:0]   xfer_out_data,
    output logic                                xfer_out_last,
    input  logic                                xfer_in_valid,
    input  logic [ADDR_W+DATA_W/8+DATA_W-1:0]   xfer_in_data,
    input  logic                                xfer_in_last,
    output logic [$clog2(DEPTH+1)-1:0]          count
);
    localparam int BE_W  = DATA_W / 8;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              idle, drain, unload, reload;
    logic              last_beat, clr;
    logic [IDX_W-1:0]  ptr;
    logic              full, st_hit, buf_hit;
    logic              st_take, st_buf, arr_st_en, rl_en;
    logic [DATA_W-1:0] buf_data, rd_data, rl_data;
    logic [BE_W-1:0]   buf_be, rd_be, rl_be;
    logic [ADDR_W-1:0] rd_addr, rl_addr;

    // Decide whether a store is taken, buffered or refused.
    always_comb begin
        st_ready  = idle && !cmd_valid;
        st_take   = st_valid && st_ready;
        st_buf    = st_take && !st_direct;
        trap_full = st_buf && full && !st_hit;
        arr_st_en = st_buf && !trap_full;
    end

    // Split an incoming restore word into its fields.
    always_comb begin
        rl_en                     = reload && xfer_in_valid;
        {rl_addr, rl_be, rl_data} = xfer_in_data;
    end

    // Share the memory port between drain beats and direct stores.
    always_comb begin
        mem_we    = drain || (st_take && st_direct);
        mem_addr  = drain ? rd_addr : st_addr;
        mem_wdata = drain ? rd_data : st_data;
        mem_be    = drain ? rd_be   : st_be;
    end

    // Present the pointed-to entry on the save port.
    always_comb begin
        xfer_out_valid = unload;
        xfer_out_last  = unload && last_beat;
        xfer_out_data  = {rd_addr, rd_be, rd_data};
    end

    assign ld_hit = buf_hit;

    sb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .count         (count),
        .xfer_in_valid (xfer_in_valid),
        .xfer_in_last  (xfer_in_last),
        .idle          (idle),
        .drain         (drain),
        .unload        (unload),
        .reload        (reload),
        .ptr           (ptr),
        .last_beat     (last_beat),
        .clr           (clr),
        .op_done       (op_done)
    );

    sb_entry_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_en   (arr_st_en),
        .st_addr (st_addr),
        .st_data (st_data),
        .st_be   (st_be),
        .rl_en   (rl_en),
        .rl_addr (rl_addr),
        .rl_data (rl_data),
        .rl_be   (rl_be),
        .clr     (clr),
        .ld_addr (ld_addr),
        .rd_idx  (ptr),
        .count   (count),
        .full    (full),
        .st_hit  (st_hit),
        .ld_hit  (buf_hit),
        .ld_dat  (buf_data),
        .ld_be   (buf_be),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .rd_be   (rd_be)
    );

    sb_byte_merge #(.DATA_W(DATA_W)) u_merge (
        .hit      (buf_hit),
        .buf_data (buf_data),
        .buf_be   (buf_be),
        .mem_data (mem_rdata),
        .merged   (ld_data)
    );

    AST_NO_EARLY_PUBLISH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_direct && !drain) |-> !mem_we); // R1

    AST_TRAP_DROPS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_full |=> (count == $past(count))); // R3

    AST_DIRECT_KEEPS_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && st_direct) |=> (count == $past(count))); // R8
endmodule

// File: tb/sb_store_buffer_test.sv
`timescale 1ns/1ps
module sb_store_buffer_test;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int BW = DW / 8;
    localparam int D  = 4;
    localparam int WW = AW + BW + DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 0, st_direct = 0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [BW-1:0] st_be = '0;
    logic          st_ready, trap_full;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] mem_rdata, ld_data;
    logic          ld_hit;
    logic          cmd_valid = 0;
    logic [1:0]    cmd_op = 2'd3;
    logic          op_done, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [BW-1:0] mem_be;
    logic          xfer_out_valid, xfer_out_last;
    logic [WW-1:0] xfer_out_data;
    logic          xfer_in_valid = 0, xfer_in_last = 0;
    logic [WW-1:0] xfer_in_data = '0;
    logic [2:0]    count;

    int n_chk = 0;
    int n_fail = 0;

    logic [AW-1:0] m_addr [D];
    logic [DW-1:0] m_data [D];
    logic [BW-1:0] m_be   [D];
    int            m_cnt = 0;
    logic [WW-1:0] saved [8];

    function automatic logic [DW-1:0] memv(input logic [AW-1:0] a);
        return {a, ~a, a ^ 4'h5, 4'h9};
    endfunction

    assign mem_rdata = memv(ld_addr);

    always #2.5 clk = ~clk;

    sb_store_buffer #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(D)) uut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int m_find(input logic [AW-1:0] a);
        for (int i = 0; i < m_cnt; i++) if (m_addr[i] == a) return i;
        return -1;
    endfunction

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [BW-1:0] be, input logic direct);
        int k;
        @(negedge clk);
        st_valid = 1; st_direct = direct; st_addr = a; st_data = d; st_be = be;
        #1;
        k = m_find(a);
        if (direct) begin
            chk("R8 direct write strobe", mem_we, 1);
            chk("R8 direct write word", {mem_addr, mem_be, mem_wdata}, {a, be, d});
        end else if (k < 0 && m_cnt == D) begin
            chk("R3 trap on full", trap_full, 1);
        end else begin
            chk("R1 no publish", mem_we, 0);
            chk(k < 0 ? "R1 no trap" : "R4 no trap on merge", trap_full, 0);
        end
        @(posedge clk);
        #1 st_valid = 0;
        if (!direct) begin
            if (k >= 0) begin
                for (int b = 0; b < BW; b++) if (be[b]) m_data[k][8*b +: 8] = d[8*b +: 8];
                m_be[k] = m_be[k] | be;
            end else if (m_cnt < D) begin
                m_addr[m_cnt] = a; m_data[m_cnt] = d; m_be[m_cnt] = be; m_cnt++;
            end
        end
        chk(direct ? "R8 count kept" : (k >= 0 ? "R4 count kept" : "R1/R3 count"), count, m_cnt);
    endtask

    task automatic load_sweep(input string req);
        for (int a = 0; a < 16; a++) begin
            int k;
            logic [DW-1:0] e;
            ld_addr = a[AW-1:0];
            #0.1;
            k = m_find(a[AW-1:0]);
            e = memv(a[AW-1:0]);
            if (k >= 0)
                for (int b = 0; b < BW; b++) if (m_be[k][b]) e[8*b +: 8] = m_data[k][8*b +: 8];
            chk(req, {ld_hit, ld_data}, {(k >= 0), e});
        end
    endtask

    task automatic issue(input logic [1:0] op);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op;
        #1 chk("R9 no store beside command", st_ready, 0);
        @(posedge clk);
        #1 cmd_valid = 0; cmd_op = 2'd3;
    endtask

    task automatic do_commit();
        int n = m_cnt;
        issue(2'd0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            st_valid = (i < n - 1); st_direct = 0; st_addr = 4'hF; st_be = 2'b11;
            #1;
            chk("R2 drain beat", {mem_we, mem_addr, mem_be, mem_wdata}, {1'b1, m_addr[i], m_be[i], m_data[i]});
            chk("R9 stall during commit", st_ready, 0);
        end
        st_valid = 0;
        @(negedge clk); #1;
        chk("R2 done pulse", {op_done, mem_we}, 2'b10);
        chk("R2 empty after commit", count, 0);
        m_cnt = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset outputs", {count, st_ready, trap_full, mem_we, op_done, xfer_out_valid}, {3'd0, 5'b10000});
        rst_n = 1;
        load_sweep("R5 empty buffer");

        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < D; k++)
                do_store(4'((r * 7 + k * 5) % 16), 16'(r * 16'h1357 + k * 16'h0F0F + 1),
                         2'(k % 3 + 1), 0);
            do_store(4'((r * 7 + 5) % 16), 16'hA5C3 ^ 16'(r), 2'(r % 2 + 1), 0);
            do_store(4'((r * 7 + 20) % 16), 16'hDEAD, 2'b11, 0);
            load_sweep("R5/R3 forward after fill");
            do_commit();
        end

        issue(2'd0);
        @(negedge clk); #1;
        chk("R2 empty commit", {op_done, mem_we}, 2'b10);
        issue(2'd3);
        @(negedge clk); #1;
        chk("R9 op 3 ignored", {op_done, st_ready}, 2'b01);

        do_store(4'h6, 16'h1234, 2'b01, 1);
        load_sweep("R8 buffer untouched");

        do_store(4'h2, 16'h1111, 2'b01, 0);
        do_store(4'h9, 16'h2222, 2'b10, 0);
        do_store(4'hC, 16'h3333, 2'b11, 0);
        issue(2'd1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk("R6 save word", {xfer_out_valid, xfer_out_last, xfer_out_data},
                {1'b1, (i == 2), m_addr[i], m_be[i], m_data[i]});
            chk("R9 stall during save", st_ready, 0);
            chk("R6 no publish on save", mem_we, 0);
            saved[i] = xfer_out_data;
        end
        @(negedge clk); #1;
        chk("R6 save done", {op_done, xfer_out_valid, count}, {2'b10, 3'd0});
        m_cnt = 0;
        load_sweep("R6 empty after save");

        saved[3] = {4'h0, 2'b11, 16'h4444};
        saved[4] = {4'h5, 2'b11, 16'h5555};
        for (int pass = 0; pass < 2; pass++) begin
            int n = (pass == 0) ? 3 : 5;
            issue(2'd2);
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                xfer_in_valid = 1; xfer_in_data = saved[i]; xfer_in_last = (i == n - 1);
                #1 chk("R9 stall during restore", st_ready, 0);
                @(posedge clk);
                #1;
            end
            xfer_in_valid = 0; xfer_in_last = 0;
            m_cnt = 0;
            for (int i = 0; i < n && i < D; i++) begin
                {m_addr[i], m_be[i], m_data[i]} = saved[i];
                m_cnt++;
            end
            @(negedge clk); #1;
            chk("R7 restore done", {op_done, count}, {1'b1, 3'(m_cnt)});
            load_sweep("R7 restored contents");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule